// File: doc/BRIEF.md
# Power-Line Command Frame Transmitter

This block sends one home-control command over a power-line carrier modem. A requester hands it a house code, a key (unit or function) code and a repeat count over a valid/ready handshake. The block locks onto the mains zero-crossing input and makes one carrier decision per mains half cycle. It drives a carrier-enable output for the modem and serialises a fixed start pattern followed by the encoded house and key codes. The frame is sent the requested number of times back to back, and the block then reports completion or the reason it stopped.

Each transmission begins with a sync phase and a silent gap of six zero crossings. While the frame is on the line, every interval between crossings is checked against a window. A crossing that comes too early or too late aborts the transmission. Requests with out-of-range codes are refused at once. While a receiver signals that it is busy, no new request is taken. Timing is expressed in clock cycles through a clocks-per-millisecond parameter, and a second parameter selects 50 Hz or 60 Hz mains windows.

Top module: `plc_frame_tx`

## Requirements
- R1: A frame has 22 slots, one per zero crossing (rising and falling edges both count). Slots 0..3 carry 1,1,1,0. Slots 4..21 carry the 9-bit code word, formed as the house pattern followed by the key pattern and taken first bit first. Each bit goes out on an even slot in true form and on the following odd slot complemented. A 1 slot produces one carrier pulse and a 0 slot produces none.
- R2: A carrier pulse is high from the third clock after the zero-crossing input changes (two synchroniser flops, then the edge register) and lasts exactly CLK_KHZ clocks (1 ms).
- R3: House index h (0..15) maps to a 4-bit pattern sent in the order p3,p2,p1,p0, where p3 = h[0], p2 = NOT(h[1] XOR h[2]), p1 = NOT h[2] and p0 = h[2] XOR h[3].
- R4: A key index k below 16 sends the house pattern of k followed by 0. A key index of 16 or more sends the 4-bit binary value of k-16, most significant bit first, followed by 1.
- R5: The frame is sent exactly `reps` times with no idle slot between copies, so the carrier rises once for every 1 slot in every copy. With `reps` = 0, no carrier is produced and the block completes at the last gap crossing.
- R6: After the first crossing seen in the sync phase, the carrier stays low through the next five crossings. Slot 0 begins on the sixth crossing.
- R7: If no crossing arrives within 250*CLK_KHZ clocks, the wait is retried. After SYNC_TRIES (10) failed waits, the block finishes with err_o = 1 and code 2.
- R8: From the sync crossing onward, a crossing interval shorter than the minimum (6.0 ms at 60 Hz, 7.2 ms at 50 Hz) or a wait longer than the maximum (8.5 ms at 60 Hz, 10.2 ms at 50 Hz) drops the carrier, ends the transmission and reports err_o = 1 with code 3. No further pulses follow.
- R9: A request with a house value of 16 or more or a key value of 32 or more is refused. The cycle after acceptance shows done_o = 1, err_o = 1 and code 1, and no carrier is produced.
- R10: req_ready_o is low while rx_busy_i is high or a transmission is under way, so a held request is not taken until the receiver is idle.
- R11: After reset, carrier_o, done_o, err_o and active_o are 0, err_code_o is 0 and req_ready_o is 1 when rx_busy_i is low.
- R12: A successful transmission ends on the crossing that follows the last slot of the last copy. done_o then pulses for one clock with err_o = 0 and code 0, and it does not pulse any earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_i | input | 1 | Asynchronous mains zero-crossing level |
| rx_busy_i | input | 1 | Receiver busy; holds off new requests |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_house_i | input | 8 | House index, 0..15 legal |
| req_key_i | input | 8 | Key/function index, 0..31 legal |
| req_reps_i | input | 8 | Number of back-to-back frame copies |
| carrier_o | output | 1 | Carrier enable to the modem |
| active_o | output | 1 | Transmission in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Completion was an error (valid with done_o) |
| err_code_o | output | 2 | 0 ok, 1 refused, 2 sync lost, 3 crossing interval fault |

## Verification
The main sweep sends 32 single-copy frames. The key index runs over every value 0..31 and the house index over 0..15 twice. Every slot's carrier level and pulse width is compared against a code word computed arithmetically from the bit rules, which separates house-map and key-map faults slot by slot. A two-copy frame and a zero-copy request show that copies are seamless and that the count is honoured. Early and late crossings during the frame, a silent mains input, out-of-range house and key values, and a held-off request under receiver busy each exercise one terminating or blocking path. Each path is told apart by its completion code and the number of carrier rises.

// File: rtl/plc_tx_pkg.sv
package plc_tx_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_GAP, ST_SEND} tx_state_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_REJECT = 2'd1,
    ERR_SYNC   = 2'd2,
    ERR_FRAME  = 2'd3
  } tx_err_e;

  localparam int SLOTS       = 22;
  localparam int START_SLOTS = 4;
  localparam int CODE_BITS   = 9;

  // Letter index to line pattern; bit 3 goes out first.
  function automatic logic [3:0] house_pattern(input logic [3:0] idx);
    case (idx)
      4'd0:  return 4'b0110;
      4'd1:  return 4'b1110;
      4'd2:  return 4'b0010;
      4'd3:  return 4'b1010;
      4'd4:  return 4'b0001;
      4'd5:  return 4'b1001;
      4'd6:  return 4'b0101;
      4'd7:  return 4'b1101;
      4'd8:  return 4'b0111;
      4'd9:  return 4'b1111;
      4'd10: return 4'b0011;
      4'd11: return 4'b1011;
      4'd12: return 4'b0000;
      4'd13: return 4'b1000;
      4'd14: return 4'b0100;
      default: return 4'b1100;
    endcase
  endfunction

  // Units reuse the letter patterns with a trailing 0; functions carry a trailing 1.
  function automatic logic [4:0] key_pattern(input logic [4:0] k);
    if (k[4]) return {k[3:0], 1'b1};
    return {house_pattern(k[3:0]), 1'b0};
  endfunction

  // Line level for one slot of the frame.
  function automatic logic slot_level(input logic [CODE_BITS-1:0] code, input logic [4:0] slot);
    int j;
    if (int'(slot) < START_SLOTS) return (int'(slot) != START_SLOTS - 1);
    j = (int'(slot) - START_SLOTS) / 2;
    return code[CODE_BITS-1-j] ^ slot[0];
  endfunction

endpackage

// File: rtl/plc_zc_edge.sv
module plc_zc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], zc_i};
  end

  // Either direction of the synchronised level is a crossing.
  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/plc_interval_watch.sv
module plc_interval_watch #(
  parameter int MIN_CLKS = 6000,
  parameter int MAX_CLKS = 8500
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic short_o,
  output logic long_o
);
  localparam int CW = $clog2(MAX_CLKS + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (edge_i)                  cnt_q <= CW'(1);
    else if (cnt_q <= CW'(MAX_CLKS))  cnt_q <= cnt_q + 1'b1;
  end

  assign short_o = edge_i && (cnt_q < CW'(MIN_CLKS));
  assign long_o  = (cnt_q > CW'(MAX_CLKS));
endmodule

// File: rtl/plc_pulse_gen.sv
module plc_pulse_gen #(
  parameter int PULSE_CLKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic kill_i,
  output logic carrier_o
);
  localparam int PW = $clog2(PULSE_CLKS + 1);

  logic [PW-1:0] left_q;
  logic          on_q;

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      left_q <= '0;
      on_q   <= 1'b0;
    end else if (fire_i) begin
      left_q <= PW'(PULSE_CLKS - 1);
      on_q   <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      on_q   <= 1'b0;
    end
  end

  assign carrier_o = on_q;

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    fire_i |-> (left_q == '0)) else $error("pulse restarted while running"); // R2
endmodule

// File: rtl/plc_frame_tx.sv
module plc_frame_tx
  import plc_tx_pkg::*;
#(
  parameter int CLK_KHZ    = 1000,
  parameter bit MAINS_50HZ = 1'b0,
  parameter int SYNC_TRIES = 10,
  parameter int GAP_EDGES  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       zc_i,
  input  logic       rx_busy_i,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic [7:0] req_house_i,
  input  logic [7:0] req_key_i,
  input  logic [7:0] req_reps_i,
  output logic       carrier_o,
  output logic       active_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  localparam int PULSE_CLKS = CLK_KHZ;
  localparam int MIN_CLKS   = MAINS_50HZ ? (72 * CLK_KHZ) / 10  : 6 * CLK_KHZ;
  localparam int MAX_CLKS   = MAINS_50HZ ? (102 * CLK_KHZ) / 10 : (17 * CLK_KHZ) / 2;
  localparam int TMO_CLKS   = 250 * CLK_KHZ;
  localparam int TMO_W      = $clog2(TMO_CLKS);
  localparam int TRY_W      = $clog2(SYNC_TRIES + 1);
  localparam int GAP_W      = $clog2(GAP_EDGES + 1);

  tx_state_e             st_q;
  logic [TMO_W-1:0]      tmo_q;
  logic [TRY_W-1:0]      tries_q;
  logic [GAP_W-1:0]      gap_q;
  logic [4:0]            slot_q;
  logic [7:0]            rep_q, reps_q;
  logic [CODE_BITS-1:0]  code_q;
  logic                  done_q, err_q;
  logic [1:0]            ecode_q;

  logic zc_edge, too_short, too_long, fault, framing;
  logic accept, bad_req, last_slot, gap_end, fire, fire_level;
  logic [4:0] next_slot;

  plc_zc_edge #(.STAGES(2)) u_edge (
    .clk(clk), .rst(rst), .zc_i(zc_i), .edge_o(zc_edge)
  );

  plc_interval_watch #(.MIN_CLKS(MIN_CLKS), .MAX_CLKS(MAX_CLKS)) u_watch (
    .clk(clk), .rst(rst), .edge_i(zc_edge), .short_o(too_short), .long_o(too_long)
  );

  assign req_ready_o = (st_q == ST_IDLE) && !rx_busy_i;
  assign accept      = req_valid_i && req_ready_o;
  assign bad_req     = (req_house_i >= 8'd16) || (req_key_i >= 8'd32);
  assign framing     = (st_q == ST_GAP) || (st_q == ST_SEND);
  assign fault       = framing && (too_short || too_long);
  assign last_slot   = (slot_q == 5'(SLOTS - 1)) && (rep_q == reps_q - 8'd1);
  assign gap_end     = (gap_q == GAP_W'(GAP_EDGES - 1));
  assign next_slot   = (st_q == ST_GAP || slot_q == 5'(SLOTS - 1)) ? 5'd0 : slot_q + 5'd1;
  assign fire_level  = slot_level(code_q, next_slot);
  assign fire        = zc_edge && !fault && fire_level &&
                       (((st_q == ST_GAP) && gap_end && (reps_q != 8'd0)) ||
                        ((st_q == ST_SEND) && !last_slot));

  plc_pulse_gen #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk(clk), .rst(rst), .fire_i(fire), .kill_i(fault), .carrier_o(carrier_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tmo_q   <= '0;
      tries_q <= '0;
      gap_q   <= '0;
      slot_q  <= '0;
      rep_q   <= '0;
      reps_q  <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ecode_q <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (bad_req) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            ecode_q <= ERR_REJECT;
          end else begin
            code_q  <= {house_pattern(req_house_i[3:0]), key_pattern(req_key_i[4:0])};
            reps_q  <= req_reps_i;
            tmo_q   <= '0;
            tries_q <= '0;
            st_q    <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (zc_edge) begin
            gap_q <= '0;
            st_q  <= ST_GAP;
          end else if (tmo_q == TMO_W'(TMO_CLKS - 1)) begin
            tmo_q <= '0;
            if (tries_q == TRY_W'(SYNC_TRIES - 1)) begin
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              ecode_q <= ERR_SYNC;
            end else begin
              tries_q <= tries_q + 1'b1;
            end
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        ST_GAP, ST_SEND: begin
          if (fault) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            ecode_q <= ERR_FRAME;
          end else if (zc_edge) begin
            if (st_q == ST_GAP && !gap_end) begin
              gap_q <= gap_q + 1'b1;
            end else if ((st_q == ST_GAP && reps_q == 8'd0) || (st_q == ST_SEND && last_slot)) begin
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
              ecode_q <= ERR_NONE;
            end else begin
              if (st_q == ST_GAP)                     rep_q <= '0;
              else if (slot_q == 5'(SLOTS - 1))       rep_q <= rep_q + 8'd1;
              slot_q <= next_slot;
              st_q   <= ST_SEND;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o   = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = ecode_q;

  AST_CARRIER_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    carrier_o |-> (st_q == ST_SEND)) else $error("carrier outside frame"); // R1
  AST_REFUSE_BAD: assert property (@(posedge clk) disable iff (rst)
    (accept && bad_req) |=> (done_o && err_o && err_code_o == ERR_REJECT && !active_o)) else $error("bad request not refused"); // R9
  AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (rst)
    fault |=> (done_o && err_o && err_code_o == ERR_FRAME && !carrier_o)) else $error("interval fault not handled"); // R8
  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && rx_busy_i) |=> (st_q == ST_IDLE)) else $error("started while receiver busy"); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !active_o) else $error("done while still active"); // R12
endmodule

// File: tb/sim_plc_frame_tx.sv
module sim_plc_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 10;
  localparam int HALF  = 83;
  localparam int PULSE = KHZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zc = 1'b0;
  logic rx_busy = 1'b0;
  logic valid = 1'b0;
  logic [7:0] house = '0, key = '0, reps = '0;
  logic ready, carrier, active, done, err;
  logic [1:0] ecode;

  int checks = 0, fails = 0;
  int done_cnt = 0, rises = 0, last_code = 0, last_err = 0;
  logic prev_car = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plc_frame_tx #(.CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst(rst), .zc_i(zc), .rx_busy_i(rx_busy),
    .req_valid_i(valid), .req_ready_o(ready),
    .req_house_i(house), .req_key_i(key), .req_reps_i(reps),
    .carrier_o(carrier), .active_o(active), .done_o(done),
    .err_o(err), .err_code_o(ecode)
  );

  always @(negedge clk) begin
    if (done) begin
      done_cnt  <= done_cnt + 1;
      last_code <= int'(ecode);
      last_err  <= int'(err);
    end
    if (carrier && !prev_car) rises <= rises + 1;
    prev_car <= carrier;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] hp(input int h);
    logic [3:0] b;
    b = 4'(h);
    return {b[0], ~(b[1] ^ b[2]), ~b[2], b[2] ^ b[3]};
  endfunction

  function automatic logic [4:0] kp(input int k);
    if (k >= 16) return {4'(k - 16), 1'b1};
    return {hp(k), 1'b0};
  endfunction

  function automatic logic exp_level(input int h, input int k, input int s);
    logic [8:0] w;
    w = {hp(h), kp(k)};
    if (s < 4) return (s != 3);
    return w[8 - (s - 4) / 2] ^ logic'(s % 2);
  endfunction

  // Called at a negedge: flip zc, then watch carrier for gap clocks.
  task automatic zc_step(input logic expb, input int gap, input bit chk, input string tag);
    zc = ~zc;
    for (int c = 1; c <= gap; c++) begin
      @(negedge clk);
      if (chk) begin
        if (c == 3 || c == PULSE + 2) check(carrier == expb, tag, int'(carrier), int'(expb));
        if (c == PULSE + 3) check(carrier == 1'b0, {tag, " R2 width"}, int'(carrier), 0);
      end
    end
  endtask

  task automatic issue(input int h, input int k, input int r);
    house = 8'(h); key = 8'(k); reps = 8'(r);
    valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic frame_body(input int h, input int k, input int r, input string tag);
    int pre_d, pre_r, ones;
    pre_d = done_cnt; pre_r = rises; ones = 0;
    zc_step(1'b0, HALF, 1'b0, "sync");
    for (int g = 1; g <= 5; g++) zc_step(1'b0, HALF, 1'b1, "R6 gap silent");
    for (int q = 0; q < r; q++)
      for (int s = 0; s < 22; s++) begin
        logic b;
        b = exp_level(h, k, s);
        if (b) ones++;
        zc_step(b, HALF, 1'b1, tag);
      end
    check(done_cnt == pre_d, "R12 no early done", done_cnt - pre_d, 0);
    zc_step(1'b0, 8, 1'b0, "end");
    check(done_cnt == pre_d + 1, "R12 done pulse", done_cnt - pre_d, 1);
    check(last_code == 0 && last_err == 0, "R12 ok code", last_code, 0);
    check(rises - pre_r == ones, "R5 carrier rises", rises - pre_r, ones);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int pre_d, pre_r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!carrier && !active && !done && !err && ecode == 2'd0, "R11 outputs idle", int'(carrier), 0);
    check(ready == 1'b1, "R11 ready", int'(ready), 1);

    // R10 busy holds off a valid request
    rx_busy = 1'b1;
    house = 8'd0; key = 8'd0; reps = 8'd1; valid = 1'b1;
    repeat (4) @(negedge clk);
    check(ready == 1'b0, "R10 ready low when busy", int'(ready), 0);
    check(active == 1'b0, "R10 not started", int'(active), 0);
    rx_busy = 1'b0;
    @(negedge clk);
    valid = 1'b0;
    check(active == 1'b1, "R10 starts after busy", int'(active), 1);
    check(ready == 1'b0, "R10 ready low when active", int'(ready), 0);
    frame_body(0, 0, 1, "R1 busy frame");

    // R1 R3 R4 sweep over all keys and all houses
    for (int i = 0; i < 32; i++) begin
      issue(i % 16, i, 1);
      frame_body(i % 16, i, 1, (i < 16) ? "R3 R1 unit frame" : "R4 R1 function frame");
    end

    // R5 back-to-back copies and zero copies
    issue(9, 20, 2);
    frame_body(9, 20, 2, "R5 two copies");
    issue(3, 5, 0);
    frame_body(3, 5, 0, "R5 zero copies");

    // R9 refused requests
    pre_d = done_cnt; pre_r = rises;
    issue(16, 0, 2);
    @(negedge clk);
    check(done_cnt == pre_d + 1 && last_code == 1 && last_err == 1, "R9 house refused", last_code, 1);
    check(active == 1'b0, "R9 stays idle", int'(active), 0);
    issue(0, 32, 2);
    @(negedge clk);
    check(done_cnt == pre_d + 2 && last_code == 1, "R9 key refused", last_code, 1);
    repeat (20) @(negedge clk);
    check(rises == pre_r, "R9 no carrier", rises - pre_r, 0);

    // R8 crossing too early
    pre_d = done_cnt; pre_r = rises;
    issue(2, 2, 1);
    zc_step(1'b0, HALF, 1'b0, "sync");
    zc_step(1'b0, HALF, 1'b0, "gap");
    zc_step(1'b0, 50, 1'b0, "gap");
    zc_step(1'b0, 8, 1'b0, "early");
    check(done_cnt == pre_d + 1 && last_code == 3 && last_err == 1, "R8 early crossing", last_code, 3);
    check(rises == pre_r, "R8 no pulse after early", rises - pre_r, 0);

    // R8 crossing too late, during the frame
    pre_d = done_cnt; pre_r = rises;
    issue(4, 7, 1);
    zc_step(1'b0, HALF, 1'b0, "sync");
    for (int g = 1; g <= 5; g++) zc_step(1'b0, HALF, 1'b0, "gap");
    for (int s = 0; s < 3; s++) zc_step(1'b1, HALF, 1'b1, "R1 start slots");
    repeat (40) @(negedge clk);
    check(done_cnt == pre_d + 1 && last_code == 3, "R8 late crossing", last_code, 3);
    check(carrier == 1'b0 && rises - pre_r == 3, "R8 no pulse after late", rises - pre_r, 3);

    // R7 no crossings at all
    pre_d = done_cnt;
    issue(1, 1, 1);
    repeat (24000) @(negedge clk);
    check(done_cnt == pre_d, "R7 still retrying", done_cnt - pre_d, 0);
    repeat (1200) @(negedge clk);
    check(done_cnt == pre_d + 1 && last_code == 2 && last_err == 1, "R7 sync error", last_code, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule